// File: doc/BRIEF.md
# Five-Level Phase-Shifted Carrier Modulator

This block turns a sampled, signed sinusoidal reference word into the five gate drive signals of one five-switch power cell that can produce five output levels: full positive, half positive, zero, half negative and full negative. It builds one triangular carrier with an up/down counter whose period is derived from the system clock frequency and the wanted carrier frequency. It forms a second carrier by reflecting the first about its peak. Over a symmetric triangle this reflection is the same as a shift of half a period.

The reference is rectified and scaled by a modulation index to give the first comparison level. The second comparison level is the first one lowered by one carrier amplitude. The two comparisons give a magnitude: full, half or zero. The sign bit of the raw reference then picks the polarity. A fixed state table maps the signed level onto the five switches. The zero level has two legal switch patterns, and the block alternates between them once per carrier period so that both switch pairs share the zero-state conduction.

The sine source, dead-time insertion and the power stage sit outside the block. The gate outputs are registered and go off under a synchronous reset.

Top module: `pwm5_cps_mod`

## Requirements
- R1: With TOP = CLK_HZ / (2·CARRIER_HZ) (TOP ≥ 2), carrier A steps by exactly one per clock through 0, 1 … TOP, TOP−1 … 1 and then repeats. Its period is 2·TOP clocks, and it is 0 in the first cycle after reset.
- R2: Carrier B equals TOP minus carrier A, which places it half a carrier period away from carrier A.
- R3: The first level is L1 = (|ref_i| · mi_i · 2·TOP) >> (REF_W + MI_W − 2). Here ref_i is two's complement and a value of 2^(REF_W−1) means 1.0, and mi_i is unsigned and 2^(MI_W−1) means an index of 1.0. L1 is registered, and it is 0 in the cycle after mi_i was 0.
- R4: Full magnitude is chosen when L1 − TOP exceeds carrier B. Otherwise half magnitude is chosen when L1 exceeds carrier A. Otherwise the magnitude is zero. Over one carrier period with a steady input, this gives C(L1−TOP) full cycles and C(L1) − C(L1−TOP) half cycles, where C(x) = 0 for x ≤ 0, 2x−1 for 0 < x ≤ TOP, and 2·TOP otherwise.
- R5: If the sign bit of ref_i is 0, only positive levels are produced. If it is 1, only negative levels are produced.
- R6: gate_o bit k drives switch k+1. The patterns as gate_o[4:0] are: +full 5'b10010, +half 5'b10001, −half 5'b01001, −full 5'b01100.
- R7: Zero uses 5'b10100 during even carrier periods, counted from 0 at reset, and 5'b01010 during odd periods. The pattern changes only at a period boundary.
- R8: While rst is high at a clock edge, gate_o goes to 5'b00000 at that edge.
- R9: Outside reset, exactly one of switches 4 and 5 is on, and switches 2 and 3 are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | REF_W | Signed sampled sinusoidal reference |
| mi_i | input | MI_W | Unsigned modulation index, 2^(MI_W−1) = 1.0 |
| gate_o | output | 5 | Registered gate drives, bit k for switch k+1 |

## Verification
The properties assume that the parameters give TOP of at least 2 and that reset is held for at least one edge. Inputs may change on any cycle. The duty-count checks, however, rely on ref_i and mi_i being steady for a full carrier period plus the two-register latency. The bench therefore changes the inputs only at a falling edge, waits four cycles, and then counts exactly 2·TOP consecutive outputs. The sweep covers every reference code of a small configuration, including the most negative code, across indices of zero, below one, exactly one and above one.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;

  typedef enum logic [2:0] {
    LVL_ZERO     = 3'd0,
    LVL_POS_HALF = 3'd1,
    LVL_POS_FULL = 3'd2,
    LVL_NEG_HALF = 3'd3,
    LVL_NEG_FULL = 3'd4
  } lvl_e;

  // bit k of a pattern drives switch k+1
  localparam logic [4:0] PAT_POS_FULL = 5'b10010;
  localparam logic [4:0] PAT_POS_HALF = 5'b10001;
  localparam logic [4:0] PAT_NEG_HALF = 5'b01001;
  localparam logic [4:0] PAT_NEG_FULL = 5'b01100;
  localparam logic [4:0] PAT_ZERO_EVN = 5'b10100;
  localparam logic [4:0] PAT_ZERO_ODD = 5'b01010;

  function automatic logic pat_is_zero(input logic [4:0] g);
    return (g == PAT_ZERO_EVN) || (g == PAT_ZERO_ODD);
  endfunction

  function automatic logic pat_is_legal(input logic [4:0] g);
    return pat_is_zero(g) || (g == PAT_POS_FULL) || (g == PAT_POS_HALF) ||
           (g == PAT_NEG_HALF) || (g == PAT_NEG_FULL);
  endfunction

endpackage

// File: rtl/pwm5_carrier.sv
module pwm5_carrier #(
  parameter int TOP = 25000,
  parameter int CW  = 15
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] car_a_o,
  output logic [CW-1:0] car_b_o,
  output logic          per_o
);
  localparam logic [CW-1:0] TOP_V = CW'(TOP);

  logic [CW-1:0] cnt_q;
  logic          up_q;
  logic          per_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      per_q <= 1'b0;
    end else if (up_q) begin
      if (cnt_q == TOP_V) begin
        cnt_q <= TOP_V - 1'b1;
        up_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == CW'(1)) begin
        cnt_q <= '0;
        up_q  <= 1'b1;
        per_q <= ~per_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign car_a_o = cnt_q;
  assign car_b_o = TOP_V - cnt_q;
  assign per_o   = per_q;

  // R1: carrier never leaves its range
  a_r1_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP_V);

  // R1: carrier moves by exactly one each clock
  a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (({1'b0, cnt_q} == {1'b0, $past(cnt_q)} + 1'b1) ||
                     ({1'b0, cnt_q} + 1'b1 == {1'b0, $past(cnt_q)})));

  // R7: period parity changes only when the carrier lands on zero
  a_r7_parity_at_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (per_q != $past(per_q))) |-> (cnt_q == '0));

endmodule

// File: rtl/pwm5_refshape.sv
module pwm5_refshape #(
  parameter int REF_W = 16,
  parameter int MI_W  = 8,
  parameter int TOP   = 25000,
  parameter int CW    = 15,
  parameter int RW    = 17
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic        [MI_W-1:0]  mi_i,
  output logic        [RW-1:0]    lvl1_o,
  output logic                    neg_o
);
  localparam int PW = REF_W + MI_W + CW + 2;
  localparam int SH = REF_W + MI_W - 2;

  logic [REF_W-1:0] mag;
  logic [PW-1:0]    prod;
  logic [RW-1:0]    lvl1_q;
  logic             neg_q;

  always_comb begin
    mag  = ref_i[REF_W-1] ? REF_W'(-ref_i) : REF_W'(ref_i);
    prod = PW'(mag) * PW'(mi_i) * PW'(2 * TOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl1_q <= '0;
      neg_q  <= 1'b0;
    end else begin
      lvl1_q <= RW'(prod >> SH);
      neg_q  <= ref_i[REF_W-1];
    end
  end

  assign lvl1_o = lvl1_q;
  assign neg_o  = neg_q;

  // R3: a zero index always yields a zero first level
  a_r3_zero_index: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mi_i) == '0)) |-> (lvl1_q == '0));

  // R5: polarity follows the reference sign one cycle later
  a_r5_sign_track: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (neg_q == $past(ref_i[REF_W-1])));

endmodule

// File: rtl/pwm5_slicer.sv
module pwm5_slicer
  import pwm5_pkg::*;
#(
  parameter int TOP = 25000,
  parameter int CW  = 15,
  parameter int RW  = 17
) (
  input  logic [RW-1:0] lvl1_i,
  input  logic          neg_i,
  input  logic [CW-1:0] car_a_i,
  input  logic [CW-1:0] car_b_i,
  output lvl_e          lvl_o
);
  logic hit_full;
  logic hit_half;

  // L1 - TOP > carrier B is rewritten as L1 > TOP + carrier B
  always_comb begin
    hit_full = lvl1_i > (RW'(TOP) + RW'(car_b_i));
    hit_half = lvl1_i > RW'(car_a_i);
    if (hit_full)
      lvl_o = neg_i ? LVL_NEG_FULL : LVL_POS_FULL;
    else if (hit_half)
      lvl_o = neg_i ? LVL_NEG_HALF : LVL_POS_HALF;
    else
      lvl_o = LVL_ZERO;
  end

endmodule

// File: rtl/pwm5_gatedec.sv
module pwm5_gatedec
  import pwm5_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lvl_e       lvl_i,
  input  logic       per_i,
  output logic [4:0] gate_o
);
  logic [4:0] gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 5'b00000;
    end else begin
      case (lvl_i)
        LVL_POS_FULL: gate_q <= PAT_POS_FULL;
        LVL_POS_HALF: gate_q <= PAT_POS_HALF;
        LVL_NEG_HALF: gate_q <= PAT_NEG_HALF;
        LVL_NEG_FULL: gate_q <= PAT_NEG_FULL;
        default:      gate_q <= per_i ? PAT_ZERO_ODD : PAT_ZERO_EVN;
      endcase
    end
  end

  assign gate_o = gate_q;

  // R8: reset leaves every switch off
  a_r8_reset_off: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gate_q == 5'b00000));

  // R6: only table patterns appear once running
  a_r6_legal_pattern: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pat_is_legal(gate_q));

  // R9: leg exclusivity
  a_r9_leg_excl: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((gate_q[3] ^ gate_q[4]) && !(gate_q[1] && gate_q[2])));

  // R7: a swap between the two zero patterns needs a period boundary
  a_r7_swap_on_period: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && pat_is_zero(gate_q) &&
     pat_is_zero($past(gate_q)) && (gate_q != $past(gate_q)))
    |-> ($past(per_i) != $past(per_i, 2)));

endmodule

// File: rtl/pwm5_cps_mod.sv
module pwm5_cps_mod
  import pwm5_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int CARRIER_HZ = 1_000,
  parameter int REF_W      = 16,
  parameter int MI_W       = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic        [MI_W-1:0]  mi_i,
  output logic        [4:0]       gate_o
);
  localparam int TOP = CLK_HZ / (2 * CARRIER_HZ);
  localparam int CW  = $clog2(TOP + 1);
  localparam int RW  = CW + 2;

  logic [CW-1:0] car_a;
  logic [CW-1:0] car_b;
  logic          per;
  logic [RW-1:0] lvl1;
  logic          neg;
  lvl_e          lvl;

  pwm5_carrier #(.TOP(TOP), .CW(CW)) carrier_i (
    .clk     (clk),
    .rst     (rst),
    .car_a_o (car_a),
    .car_b_o (car_b),
    .per_o   (per)
  );

  pwm5_refshape #(
    .REF_W (REF_W),
    .MI_W  (MI_W),
    .TOP   (TOP),
    .CW    (CW),
    .RW    (RW)
  ) refshape_i (
    .clk    (clk),
    .rst    (rst),
    .ref_i  (ref_i),
    .mi_i   (mi_i),
    .lvl1_o (lvl1),
    .neg_o  (neg)
  );

  pwm5_slicer #(.TOP(TOP), .CW(CW), .RW(RW)) slicer_i (
    .lvl1_i  (lvl1),
    .neg_i   (neg),
    .car_a_i (car_a),
    .car_b_i (car_b),
    .lvl_o   (lvl)
  );

  pwm5_gatedec gatedec_i (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (lvl),
    .per_i  (per),
    .gate_o (gate_o)
  );

  // R2: the two carriers always sum to the peak value
  a_r2_mirror_sum: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, car_a} + {1'b0, car_b}) == (CW + 1)'(TOP));

endmodule

// File: tb/pwm5_cps_mod_tb_top.sv
module pwm5_cps_mod_tb_top;
  localparam int CLK_HZ     = 40;
  localparam int CARRIER_HZ = 1;
  localparam int REF_W      = 6;
  localparam int MI_W       = 4;
  localparam int TOP        = CLK_HZ / (2 * CARRIER_HZ);
  localparam int PER        = 2 * TOP;

  localparam logic [4:0] P_PF = 5'b10010;
  localparam logic [4:0] P_PH = 5'b10001;
  localparam logic [4:0] P_NH = 5'b01001;
  localparam logic [4:0] P_NF = 5'b01100;
  localparam logic [4:0] P_ZE = 5'b10100;
  localparam logic [4:0] P_ZO = 5'b01010;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic signed [REF_W-1:0] ref_i = '0;
  logic        [MI_W-1:0]  mi_i = '0;
  logic        [4:0]       gate_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  pwm5_cps_mod #(
    .CLK_HZ(CLK_HZ), .CARRIER_HZ(CARRIER_HZ), .REF_W(REF_W), .MI_W(MI_W)
  ) dut_i (
    .clk(clk), .rst(rst), .ref_i(ref_i), .mi_i(mi_i), .gate_o(gate_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int c_above(input int x);
    if (x <= 0) return 0;
    if (x <= TOP) return 2 * x - 1;
    return 2 * TOP;
  endfunction

  task automatic sweep_one(input int sref, input int mi);
    int mag, l1, e_full, e_half, e_zero;
    int n_pf, n_ph, n_nf, n_nh, n_z, n_ill;
    bit negv;
    @(negedge clk);
    ref_i = REF_W'(sref);
    mi_i  = MI_W'(mi);
    repeat (4) @(negedge clk);
    n_pf = 0; n_ph = 0; n_nf = 0; n_nh = 0; n_z = 0; n_ill = 0;
    for (int i = 0; i < PER; i++) begin
      case (gate_o)
        P_PF: n_pf++;
        P_PH: n_ph++;
        P_NF: n_nf++;
        P_NH: n_nh++;
        P_ZE, P_ZO: n_z++;
        default: n_ill++;
      endcase
      if (i != PER - 1) @(negedge clk);
    end
    negv   = sref < 0;
    mag    = negv ? -sref : sref;
    l1     = (mag * mi * 2 * TOP) >> (REF_W + MI_W - 2);
    e_full = c_above(l1 - TOP);
    e_half = c_above(l1) - e_full;
    e_zero = PER - e_full - e_half;
    // R1 R2 R3 R4: counts over one carrier period
    check((negv ? n_nf : n_pf) == e_full, "R4 full count (R1 R2 R3)",
          negv ? n_nf : n_pf, e_full);
    check((negv ? n_nh : n_ph) == e_half, "R4 half count (R3)",
          negv ? n_nh : n_ph, e_half);
    check(n_z == e_zero, "R4 zero count", n_z, e_zero);
    check((negv ? (n_pf + n_ph) : (n_nf + n_nh)) == 0, "R5 wrong polarity",
          negv ? (n_pf + n_ph) : (n_nf + n_nh), 0);
    check(n_ill == 0, "R6 R9 illegal pattern", n_ill, 0);
  endtask

  initial begin
    int mis[5] = '{0, 3, 8, 11, 15};
    // R8: outputs off during reset
    repeat (3) @(negedge clk);
    check(gate_o == 5'b00000, "R8 reset state", gate_o, 0);
    rst = 1'b0;
    // R7: zero pattern alternates each period, even first
    for (int k = 0; k < 3 * PER; k++) begin
      @(negedge clk);
      if (k == 0 || k == PER - 1 || k == 2 * PER)
        check(gate_o == P_ZE, "R7 even-period zero", gate_o, P_ZE);
      if (k == PER || k == 2 * PER - 1)
        check(gate_o == P_ZO, "R7 odd-period zero", gate_o, P_ZO);
    end
    // R3 R4 R5 R6: sweep every reference code at several indices
    for (int m = 0; m < 5; m++)
      for (int r = -(1 << (REF_W - 1)); r < (1 << (REF_W - 1)); r++)
        sweep_one(r, mis[m]);
    // R8: mid-run reset clears gates at the next edge
    @(negedge clk);
    ref_i = REF_W'(31);
    mi_i  = MI_W'(15);
    repeat (5) @(negedge clk);
    check(gate_o != 5'b00000, "R8 running before reset", gate_o, 1);
    rst = 1'b1;
    @(negedge clk);
    check(gate_o == 5'b00000, "R8 synchronous clear", gate_o, 0);
    @(negedge clk);
    check(gate_o == 5'b00000, "R8 held clear", gate_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(gate_o == P_ZE, "R7 R8 first output after reset", gate_o, P_ZE);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule